// File: doc/BRIEF.md
# Call-Site Dispatch Result Cache

This block is a small fully associative table that remembers recent outcomes of dynamic method dispatch. Each entry is identified by two things together: the program counter of a call site and the runtime type identifier of the receiver object. The entry stores a payload and a one-bit kind flag. With the flag clear, the payload is the entry point of the resolved method. With the flag set, the method is a trivial accessor, and the payload is a byte displacement from the object base.

A consumer presents a call-site PC and type ID on the probe port. It receives a hit indication, the kind flag and the payload in the same cycle, with no register in that path. Software resolution handlers fill the table through the record port, one entry per cycle. A clear input drops every entry at once. Replacement is least recently used over eight slots, and both probe hits and records count as uses.

Top module: `dispatch_cache`

## Requirements
- R1: After reset deasserts, no probe hits until a record has been written.
- R2: A probe hits only when a valid entry holds both the probed PC and the probed type ID. A match on only one of the two is a miss.
- R3: On a hit, `pr_accessor` and `pr_payload` show the kind flag and payload last recorded for that key, in the same cycle as the probe inputs. A flag of 1 means accessor (payload is a byte displacement). A flag of 0 means method (payload is a target address).
- R4: A record whose key is already present replaces that entry's flag and payload in place. No second copy is made, and no other entry is disturbed.
- R5: While any slot is empty, a record of a new key goes to an empty slot and no stored key is lost.
- R6: When all eight slots are full, a record of a new key evicts the least recently used key. A probe hit or a record marks its key as most recently used. When both happen in one cycle, the probe's use counts first and the record's use counts second.
- R7: Asserting `clr` for one cycle removes every entry, so every probe in the following cycle misses. A record in the same cycle as `clr` is discarded.
- R8: A record becomes visible to probes from the next cycle. A probe in the same cycle as the record sees the table as it was before the record.
- R9: On a miss, `pr_accessor` is 0 and `pr_payload` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Drop all entries |
| pr_pc | input | PC_W | Probe call-site PC |
| pr_type | input | TYPE_W | Probe type ID |
| pr_hit | output | 1 | Probe found a matching entry |
| pr_accessor | output | 1 | Kind flag of the matching entry |
| pr_payload | output | PAY_W | Target address or byte displacement |
| rec_en | input | 1 | Write a record this cycle |
| rec_pc | input | PC_W | Record call-site PC |
| rec_type | input | TYPE_W | Record type ID |
| rec_accessor | input | 1 | Record kind flag |
| rec_payload | input | PAY_W | Record payload |

## Verification
A probe and a record can land in the same cycle, and this is the case that needs the most care. The bench provokes it in two ways. First, it probes the very key being recorded, and expects the old payload in that cycle and the new one in the next. Second, with the table full, it probes the oldest key while recording a new one, and expects the probed key to survive and the second-oldest key to be evicted instead. The bench model orders uses by stamping the probe's use before the record's use within each cycle. Random traffic over sixteen keys, with clears mixed in, repeats this overlap many times against that model.

// File: rtl/dispatch_cache.sv
module dispatch_cache #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int TYPE_W  = 16,
  parameter int PAY_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [PC_W-1:0]   pr_pc,
  input  logic [TYPE_W-1:0] pr_type,
  output logic              pr_hit,
  output logic              pr_accessor,
  output logic [PAY_W-1:0]  pr_payload,
  input  logic              rec_en,
  input  logic [PC_W-1:0]   rec_pc,
  input  logic [TYPE_W-1:0] rec_type,
  input  logic              rec_accessor,
  input  logic [PAY_W-1:0]  rec_payload
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  typedef logic [ENTRIES-1:0][IDX_W-1:0] age_t;

  logic [ENTRIES-1:0] vld;
  logic [PC_W-1:0]    tag_pc  [ENTRIES];
  logic [TYPE_W-1:0]  tag_ty  [ENTRIES];
  logic               acc_q   [ENTRIES];
  logic [PAY_W-1:0]   pay_q   [ENTRIES];
  age_t               age_q, age_pr, age_nx;

  logic [ENTRIES-1:0] pr_vec, rec_vec;
  logic [IDX_W-1:0]   pr_idx, rec_idx, free_idx, old_idx;
  logic               rec_hit, any_free;

  function automatic age_t touch(age_t a, logic [IDX_W-1:0] k);
    age_t r = a;
    for (int i = 0; i < ENTRIES; i++)
      if (a[i] < a[k]) r[i] = a[i] + 1'b1;
    r[k] = '0;
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pr_vec[i]  = vld[i] && tag_pc[i] == pr_pc  && tag_ty[i] == pr_type;
      rec_vec[i] = vld[i] && tag_pc[i] == rec_pc && tag_ty[i] == rec_type;
    end
  end

  always_comb begin
    pr_idx = '0; rec_idx_m = '0; free_idx = '0; any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (pr_vec[i])  pr_idx    = IDX_W'(i);
      if (rec_vec[i]) rec_idx_m = IDX_W'(i);
      if (!vld[i]) begin free_idx = IDX_W'(i); any_free = 1'b1; end
    end
  end
  logic [IDX_W-1:0] rec_idx_m;

  assign pr_hit      = |pr_vec;
  assign rec_hit     = |rec_vec;
  assign pr_accessor = pr_hit ? acc_q[pr_idx] : 1'b0;
  assign pr_payload  = pr_hit ? pay_q[pr_idx] : '0;
  assign age_pr      = pr_hit ? touch(age_q, pr_idx) : age_q;

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_pr[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
  end

  assign rec_idx = rec_hit ? rec_idx_m : (any_free ? free_idx : old_idx);
  assign age_nx  = (rec_en && !clr) ? touch(age_pr, rec_idx) : age_pr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_nx;
      if (clr) vld <= '0;
      else if (rec_en) vld[rec_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rec_en && !clr) begin
      tag_pc[rec_idx] <= rec_pc;
      tag_ty[rec_idx] <= rec_type;
      acc_q[rec_idx]  <= rec_accessor;
      pay_q[rec_idx]  <= rec_payload;
    end
  end
endmodule

module dispatch_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int TYPE_W  = 16,
  parameter int PAY_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [PC_W-1:0]   pr_pc,
  input logic [TYPE_W-1:0] pr_type,
  input logic              pr_hit,
  input logic              pr_accessor,
  input logic [PAY_W-1:0]  pr_payload,
  input logic              rec_en,
  input logic [PC_W-1:0]   rec_pc,
  input logic [TYPE_W-1:0] rec_type,
  input logic              rec_accessor,
  input logic [PAY_W-1:0]  rec_payload,
  input logic [ENTRIES-1:0] pr_vec
);
  p_clean_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pr_hit);

  p_single_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pr_vec));

  p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pr_hit);

  p_record_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && !clr) ##1 (pr_pc == $past(rec_pc) && pr_type == $past(rec_type))
      |-> (pr_hit && pr_payload == $past(rec_payload) && pr_accessor == $past(rec_accessor)));

  p_quiet_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_hit |-> (pr_payload == '0 && !pr_accessor));
endmodule

bind dispatch_cache dispatch_cache_chk #(
  .ENTRIES(ENTRIES), .PC_W(PC_W), .TYPE_W(TYPE_W), .PAY_W(PAY_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .pr_pc(pr_pc), .pr_type(pr_type),
  .pr_hit(pr_hit), .pr_accessor(pr_accessor), .pr_payload(pr_payload),
  .rec_en(rec_en), .rec_pc(rec_pc), .rec_type(rec_type),
  .rec_accessor(rec_accessor), .rec_payload(rec_payload), .pr_vec(pr_vec)
);

// File: tb/dispatch_cache_tb_top.sv
`timescale 1ns/1ps
module dispatch_cache_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [31:0] pr_pc = '0;
  logic [15:0] pr_type = '0;
  logic        pr_hit, pr_accessor;
  logic [31:0] pr_payload;
  logic        rec_en = 1'b0;
  logic [31:0] rec_pc = '0;
  logic [15:0] rec_type = '0;
  logic        rec_accessor = 1'b0;
  logic [31:0] rec_payload = '0;

  int total = 0, bad = 0, cyc = 0;
  bit          m_v [N];
  logic [31:0] m_pc [N];
  logic [15:0] m_ty [N];
  bit          m_s [N];
  logic [31:0] m_a [N];
  int          m_t [N];

  always #2.5 clk = ~clk;

  dispatch_cache dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pr_pc(pr_pc), .pr_type(pr_type),
    .pr_hit(pr_hit), .pr_accessor(pr_accessor), .pr_payload(pr_payload),
    .rec_en(rec_en), .rec_pc(rec_pc), .rec_type(rec_type),
    .rec_accessor(rec_accessor), .rec_payload(rec_payload)
  );

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic int find(logic [31:0] pc, logic [15:0] ty);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pc[i] == pc && m_ty[i] == ty) return i;
    return -1;
  endfunction

  task automatic step(string req, logic [31:0] lpc, logic [15:0] lty,
                      bit ren, logic [31:0] rpc, logic [15:0] rty, bit racc,
                      logic [31:0] rpay, bit fl);
    int j, k;
    @(negedge clk);
    pr_pc = lpc; pr_type = lty; rec_en = ren; rec_pc = rpc; rec_type = rty;
    rec_accessor = racc; rec_payload = rpay; clr = fl;
    #1;
    j = find(lpc, lty);
    check(req, {63'd0, pr_hit}, {63'd0, j >= 0});
    if (j >= 0) begin
      check("R3", {31'd0, pr_accessor, pr_payload}, {31'd0, m_s[j], m_a[j]});
    end else begin
      check("R9", {31'd0, pr_accessor, pr_payload}, 64'd0);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else begin
      if (j >= 0) m_t[j] = 2 * cyc;
      if (ren) begin
        k = find(rpc, rty);
        if (k < 0) for (int i = 0; i < N; i++) if (k < 0 && !m_v[i]) k = i;
        if (k < 0) begin
          k = 0;
          for (int i = 1; i < N; i++) if (m_t[i] < m_t[k]) k = i;
        end
        m_v[k] = 1'b1; m_pc[k] = rpc; m_ty[k] = rty; m_s[k] = racc;
        m_a[k] = rpay; m_t[k] = 2 * cyc + 1;
      end
    end
    cyc++;
  endtask

  task automatic probe(string req, logic [31:0] lpc, logic [15:0] lty);
    step(req, lpc, lty, 1'b0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic put(logic [31:0] rpc, logic [15:0] rty, bit racc, logic [31:0] rpay);
    step("R8", 32'hdead, 16'hffff, 1'b1, rpc, rty, racc, rpay, 1'b0);
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < 10; p++)
      for (int t = 0; t < 10; t++)
        probe(req, 32'h100 + 32'(p) * 4, 16'(t));
  endtask

  function automatic logic [31:0] kpc(int i);
    return 32'h100 + 32'(i) * 4;
  endfunction

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) probe("R1", kpc(i), 16'(i));
    for (int i = 0; i < N; i++) put(kpc(i), 16'(i), i[0], 32'h4000 + 32'(i) * 32'h11);
    sweep("R2");
    for (int i = 0; i < N; i++) if (i != 3) probe("R6", kpc(i), 16'(i));
    put(kpc(8), 16'd8, 1'b0, 32'h8888);
    sweep("R6");
    put(kpc(5), 16'd5, 1'b1, 32'h0000_0024);
    sweep("R4");
    step("R8", kpc(6), 16'd6, 1'b1, kpc(6), 16'd6, 1'b0, 32'h6060, 1'b0);
    probe("R8", kpc(6), 16'd6);
    for (int i = 0; i < N; i++) probe("R6", kpc(i), 16'(i));
    step("R6", kpc(8), 16'd8, 1'b1, kpc(9), 16'd9, 1'b1, 32'h99, 1'b0);
    sweep("R6");
    step("R7", kpc(1), 16'd1, 1'b1, kpc(2), 16'd1, 1'b0, 32'h77, 1'b1);
    sweep("R7");
    for (int i = 0; i < 3; i++) put(kpc(i), 16'(9 - i), 1'b0, 32'h500 + 32'(i));
    sweep("R5");
    lf = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R6", kpc(int'(lf[1:0])), 16'(lf[3:2]), lf[4] | lf[5],
           kpc(int'(lf[7:6])), 16'(lf[9:8]), lf[10], {16'd0, lf}, lf[15:11] == 5'd0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule